// File: doc/BRIEF.md
# Horizontal Blanking Pattern Generator

This block builds the per-line horizontal blanking window for a CCD timing path. It also gates the free-running horizontal shift clocks while that window is open. A pixel counter restarts at every line-start strobe. The window opens and closes each time the count meets one of six programmable toggle positions. With two positions the result is one ordinary blanking interval. With more, extra pulse groups appear inside that interval.

Each vertical sequence owns its own register set. Within a set, even lines and odd lines use separate toggle lists. Loading the same list into both removes the alternation. While the window is open, the odd-numbered shift clocks, the even-numbered shift clocks and the last-stage clock are each held at a level chosen by that sequence's park bits. Outside the window they follow their free-running sources.

A frame strobe clears the line counter, so the first line after it is line 0, which is even. The sequence select is captured only when a line starts.

Top module: `hblank_gen`

## Requirements
- R1: After reset and before any line start, `hblk` is 0 and every gated clock output equals its free-running source.
- R2: When `hd` or `vd` is high at a clock edge, `hblk` is 0 after that edge, even if a toggle position matches in that same cycle.
- R3: The pixel count is 0 in the first cycle after a line start and rises by one per cycle. An enabled toggle position equal to the count inverts `hblk` one cycle later. Two enabled positions holding the same value cancel each other.
- R4: A toggle position of all ones (255 with the default 8-bit width) is disabled. The pixel count stops at all ones, so a line longer than the counter range toggles no further.
- R5: `vd` clears the line counter, and the following line is line 0, which is even. Each `hd` without `vd` advances the line counter. Even lines use `tog_even` and odd lines use `tog_odd`.
- R6: While `hblk` is 1, all `h_odd_out` bits equal the inverse of `park_lo_h1` for the current sequence (1 parks them low). While `hblk` is 0, they equal `h1_in`.
- R7: While `hblk` is 1, all `h_even_out` bits equal the inverse of `park_lo_h2` for the current sequence. While `hblk` is 0, they equal `h2_in`.
- R8: While `hblk` is 1, `hl_out` equals the inverse of `park_lo_hl` for the current sequence. While `hblk` is 0, it equals `hl_in`.
- R9: `seq_sel` is sampled only at a line start. A change of `seq_sel` in the middle of a line has no effect on toggles or park levels until the next line start.
- R10: When `vd` and `hd` are high together, `vd` takes priority and the next line is line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vd | input | 1 | Frame strobe; starts a line and clears the line counter |
| hd | input | 1 | Line-start strobe |
| seq_sel | input | SEQ_W | Vertical sequence select, captured at line start |
| tog_even | input | NUM_SEQ*NUM_TOG*PIX_W | Toggle positions for even lines, per sequence |
| tog_odd | input | NUM_SEQ*NUM_TOG*PIX_W | Toggle positions for odd lines, per sequence |
| park_lo_h1 | input | NUM_SEQ | Per sequence: 1 holds the odd shift clocks low during blanking |
| park_lo_h2 | input | NUM_SEQ | Per sequence: 1 holds the even shift clocks low during blanking |
| park_lo_hl | input | NUM_SEQ | Per sequence: 1 holds the last-stage clock low during blanking |
| h1_in | input | 1 | Free-running odd-phase shift clock |
| h2_in | input | 1 | Free-running even-phase shift clock |
| hl_in | input | 1 | Free-running last-stage clock |
| hblk | output | 1 | Registered blanking window |
| h_odd_out | output | GRP | Gated H1/H3/H5/H7 |
| h_even_out | output | GRP | Gated H2/H4/H6/H8 |
| hl_out | output | 1 | Gated last-stage clock |

## Verification
A line start and a toggle match can land in the same cycle. One even-line toggle position is placed on the last pixel of a 40-cycle line, so its match arrives exactly when the next `hd` is driven. The window must then read 0, not inverted.

A frame strobe and a line strobe are also driven together once. The following line must use the even toggle set.

The bench computes each expected window value from the count of enabled positions below the current pixel index. It then compares every cycle's window and gated clocks against that value.

// File: rtl/hblank_pkg.sv
package hblank_pkg;

  // Forced levels applied to the three gated clock families during blanking.
  typedef struct packed {
    logic lo_h1;
    logic lo_h2;
    logic lo_hl;
  } park_t;

  // Family of a gated clock group.
  typedef enum logic [1:0] {
    FAM_ODD  = 2'd0,
    FAM_EVEN = 2'd1,
    FAM_LAST = 2'd2
  } clk_fam_e;

endpackage

// File: rtl/hb_line_timer.sv
module hb_line_timer #(
  parameter int PIX_W   = 8,
  parameter int NUM_SEQ = 2,
  parameter int SEQ_W   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vd,
  input  logic             hd,
  input  logic [SEQ_W-1:0] seq_sel,
  output logic             line_start,
  output logic [PIX_W-1:0] px,
  output logic             line_odd,
  output logic [SEQ_W-1:0] seq_cur
);

  localparam logic [PIX_W-1:0] PX_MAX = {PIX_W{1'b1}};

  logic [PIX_W-1:0] px_q, px_d;
  logic             odd_q, odd_d;
  logic [SEQ_W-1:0] seq_q, seq_d, seq_clamped;
  logic             px_en, odd_en, seq_en;

  assign line_start = vd | hd;

  always_comb begin
    if (int'(seq_sel) < NUM_SEQ) seq_clamped = seq_sel;
    else                         seq_clamped = '0;
  end

  // next-state logic
  always_comb begin
    px_en  = line_start | (px_q != PX_MAX);
    px_d   = line_start ? '0 : px_q + 1'b1;
    odd_en = line_start;
    odd_d  = vd ? 1'b0 : ~odd_q;
    seq_en = line_start;
    seq_d  = seq_clamped;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_q  <= PX_MAX;
      odd_q <= 1'b0;
      seq_q <= '0;
    end else begin
      if (px_en)  px_q  <= px_d;
      if (odd_en) odd_q <= odd_d;
      if (seq_en) seq_q <= seq_d;
    end
  end

  assign px       = px_q;
  assign line_odd = odd_q;
  assign seq_cur  = seq_q;

endmodule

// File: rtl/hb_toggle_window.sv
module hb_toggle_window #(
  parameter int PIX_W   = 8,
  parameter int NUM_TOG = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            line_start,
  input  logic [PIX_W-1:0]                px,
  input  logic [NUM_TOG-1:0][PIX_W-1:0]   tog_set,
  output logic                            hblk
);

  localparam logic [PIX_W-1:0] TOG_OFF = {PIX_W{1'b1}};

  logic [NUM_TOG-1:0] hit;
  logic               flip;
  logic               win_q, win_d;

  for (genvar i = 0; i < NUM_TOG; i++) begin : g_cmp
    assign hit[i] = (tog_set[i] != TOG_OFF) && (tog_set[i] == px);
  end

  // Positions are applied in list order; each match inverts, so the net
  // effect is the parity of the matches.
  assign flip = ^hit;

  always_comb begin
    if (line_start) win_d = 1'b0;
    else            win_d = win_q ^ flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win_d;
  end

  assign hblk = win_q;

endmodule

// File: rtl/hb_clock_gate.sv
module hb_clock_gate #(
  parameter int                   GRP = 4,
  parameter hblank_pkg::clk_fam_e FAM = hblank_pkg::FAM_ODD
) (
  input  logic           hblk,
  input  logic           park_lo,
  input  logic           clk_src,
  output logic [GRP-1:0] clk_out
);

  logic park_lvl;

  // A park bit of 1 means the family sits low while blanking.
  assign park_lvl = ~park_lo;

  for (genvar g = 0; g < GRP; g++) begin : g_lane
    if (FAM == hblank_pkg::FAM_LAST) begin : g_last
      assign clk_out[g] = hblk ? park_lvl : clk_src;
    end else begin : g_shift
      assign clk_out[g] = hblk ? park_lvl : clk_src;
    end
  end

endmodule

// File: rtl/hblank_gen.sv
module hblank_gen #(
  parameter int PIX_W   = 8,
  parameter int NUM_TOG = 6,
  parameter int NUM_SEQ = 2,
  parameter int GRP     = 4,
  parameter int SEQ_W   = (NUM_SEQ > 1) ? $clog2(NUM_SEQ) : 1
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        vd,
  input  logic                                        hd,
  input  logic [SEQ_W-1:0]                            seq_sel,
  input  logic [NUM_SEQ-1:0][NUM_TOG-1:0][PIX_W-1:0]  tog_even,
  input  logic [NUM_SEQ-1:0][NUM_TOG-1:0][PIX_W-1:0]  tog_odd,
  input  logic [NUM_SEQ-1:0]                          park_lo_h1,
  input  logic [NUM_SEQ-1:0]                          park_lo_h2,
  input  logic [NUM_SEQ-1:0]                          park_lo_hl,
  input  logic                                        h1_in,
  input  logic                                        h2_in,
  input  logic                                        hl_in,
  output logic                                        hblk,
  output logic [GRP-1:0]                              h_odd_out,
  output logic [GRP-1:0]                              h_even_out,
  output logic                                        hl_out
);

  import hblank_pkg::*;

  // asynchronous assert, synchronous release
  logic rst_meta, rst_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_q  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_q  <= rst_meta;
    end
  end

  logic                          line_start;
  logic [PIX_W-1:0]              px;
  logic                          line_odd;
  logic [SEQ_W-1:0]              seq_cur;
  logic [NUM_TOG-1:0][PIX_W-1:0] tog_act;
  park_t                         park_act;
  logic [0:0]                    hl_vec;

  hb_line_timer #(
    .PIX_W(PIX_W), .NUM_SEQ(NUM_SEQ), .SEQ_W(SEQ_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n_q), .vd(vd), .hd(hd), .seq_sel(seq_sel),
    .line_start(line_start), .px(px), .line_odd(line_odd), .seq_cur(seq_cur)
  );

  always_comb begin
    tog_act           = line_odd ? tog_odd[seq_cur] : tog_even[seq_cur];
    park_act.lo_h1    = park_lo_h1[seq_cur];
    park_act.lo_h2    = park_lo_h2[seq_cur];
    park_act.lo_hl    = park_lo_hl[seq_cur];
  end

  hb_toggle_window #(
    .PIX_W(PIX_W), .NUM_TOG(NUM_TOG)
  ) u_window (
    .clk(clk), .rst_n(rst_n_q), .line_start(line_start), .px(px),
    .tog_set(tog_act), .hblk(hblk)
  );

  hb_clock_gate #(.GRP(GRP), .FAM(FAM_ODD)) u_gate_odd (
    .hblk(hblk), .park_lo(park_act.lo_h1), .clk_src(h1_in), .clk_out(h_odd_out)
  );

  hb_clock_gate #(.GRP(GRP), .FAM(FAM_EVEN)) u_gate_even (
    .hblk(hblk), .park_lo(park_act.lo_h2), .clk_src(h2_in), .clk_out(h_even_out)
  );

  hb_clock_gate #(.GRP(1), .FAM(FAM_LAST)) u_gate_last (
    .hblk(hblk), .park_lo(park_act.lo_hl), .clk_src(hl_in), .clk_out(hl_vec)
  );

  assign hl_out = hl_vec[0];

endmodule

// File: rtl/hblank_gen_chk.sv
module hblank_gen_chk #(
  parameter int PIX_W   = 8,
  parameter int NUM_SEQ = 2,
  parameter int GRP     = 4,
  parameter int SEQ_W   = 1
) (
  input logic               clk,
  input logic               rst_n_q,
  input logic               vd,
  input logic               hd,
  input logic               hblk,
  input logic               h1_in,
  input logic               h2_in,
  input logic               hl_in,
  input logic [GRP-1:0]     h_odd_out,
  input logic [GRP-1:0]     h_even_out,
  input logic               hl_out,
  input logic [NUM_SEQ-1:0] park_lo_h1,
  input logic [NUM_SEQ-1:0] park_lo_h2,
  input logic [NUM_SEQ-1:0] park_lo_hl,
  input logic [SEQ_W-1:0]   seq_cur,
  input logic               line_odd,
  input logic [PIX_W-1:0]   px
);

  localparam logic [PIX_W-1:0] PX_MAX = {PIX_W{1'b1}};

  // R2
  line_start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (hd || vd) |=> !hblk);

  // R6
  odd_family_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    h_odd_out == (hblk ? {GRP{~park_lo_h1[seq_cur]}} : {GRP{h1_in}}));

  // R7
  even_family_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    h_even_out == (hblk ? {GRP{~park_lo_h2[seq_cur]}} : {GRP{h2_in}}));

  // R8
  last_stage_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    hl_out == (hblk ? ~park_lo_hl[seq_cur] : hl_in));

  // R9
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    !(hd || vd) |=> $stable(seq_cur));

  // R5
  parity_step_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (hd && !vd) |=> (line_odd != $past(line_odd)));

  // R10
  frame_even_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    vd |=> !line_odd);

  // R4
  px_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (!(hd || vd) && px == PX_MAX) |=> px == PX_MAX);

endmodule

bind hblank_gen hblank_gen_chk #(
  .PIX_W(PIX_W), .NUM_SEQ(NUM_SEQ), .GRP(GRP), .SEQ_W(SEQ_W)
) u_chk (
  .clk(clk), .rst_n_q(rst_n_q), .vd(vd), .hd(hd), .hblk(hblk),
  .h1_in(h1_in), .h2_in(h2_in), .hl_in(hl_in),
  .h_odd_out(h_odd_out), .h_even_out(h_even_out), .hl_out(hl_out),
  .park_lo_h1(park_lo_h1), .park_lo_h2(park_lo_h2), .park_lo_hl(park_lo_hl),
  .seq_cur(seq_cur), .line_odd(line_odd), .px(px)
);

// File: tb/test_hblank_gen.sv
module test_hblank_gen;

  localparam int PW = 8;
  localparam int NT = 6;
  localparam int NS = 2;
  localparam int GP = 4;
  localparam int LINE_LEN = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic vd, hd;
  logic [0:0] seq_sel;
  logic [NS-1:0][NT-1:0][PW-1:0] tog_even, tog_odd;
  logic [NS-1:0] park_lo_h1, park_lo_h2, park_lo_hl;
  logic h1_in, h2_in, hl_in;
  logic hblk;
  logic [GP-1:0] h_odd_out, h_even_out;
  logic hl_out;

  always #4 clk = ~clk;   // 125 MHz

  hblank_gen #(.PIX_W(PW), .NUM_TOG(NT), .NUM_SEQ(NS), .GRP(GP)) i_hblank_gen (
    .clk(clk), .rst_n(rst_n), .vd(vd), .hd(hd), .seq_sel(seq_sel),
    .tog_even(tog_even), .tog_odd(tog_odd),
    .park_lo_h1(park_lo_h1), .park_lo_h2(park_lo_h2), .park_lo_hl(park_lo_hl),
    .h1_in(h1_in), .h2_in(h2_in), .hl_in(hl_in),
    .hblk(hblk), .h_odd_out(h_odd_out), .h_even_out(h_even_out), .hl_out(hl_out)
  );

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  // bench model state
  bit   started = 1'b0;
  int   k       = 255;
  int   line_no = 0;
  logic seq_l   = 1'b0;
  bit   long_line = 1'b0;

  function automatic logic exp_window(input int kk, input logic [NT-1:0][PW-1:0] ts);
    logic p = 1'b0;
    for (int i = 0; i < NT; i++)
      if (ts[i] != 8'hFF && int'(ts[i]) < kk) p = ~p;
    return p;
  endfunction

  task automatic cmp(input string tag, input logic [GP-1:0] act, input logic [GP-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle=%0d line=%0d px=%0d actual=%b expected=%b",
               tag, cyc, line_no, k, act, exp);
    end
  endtask

  task automatic check_all();
    logic hb;
    string tag;
    logic [NT-1:0][PW-1:0] ts;
    ts = (line_no % 2 == 1) ? tog_odd[seq_l] : tog_even[seq_l];
    hb = started ? exp_window(k, ts) : 1'b0;
    if (!started)       tag = "R1";
    else if (k == 0)    tag = "R2 R10";
    else if (long_line) tag = "R4";
    else                tag = "R3 R5 R9";
    cmp({tag, " hblk"}, {{(GP-1){1'b0}}, hblk}, {{(GP-1){1'b0}}, hb});
    cmp(started ? "R6" : "R1", h_odd_out,
        hb ? {GP{~park_lo_h1[seq_l]}} : {GP{h1_in}});
    cmp(started ? "R7" : "R1", h_even_out,
        hb ? {GP{~park_lo_h2[seq_l]}} : {GP{h2_in}});
    cmp(started ? "R8" : "R1", {{(GP-1){1'b0}}, hl_out},
        {{(GP-1){1'b0}}, hb ? ~park_lo_hl[seq_l] : hl_in});
  endtask

  // Called at a falling edge: drive, wait one rising edge, update model, check.
  task automatic tick(input logic hd_v, input logic vd_v, input logic sq);
    hd = hd_v; vd = vd_v; seq_sel = sq;
    h1_in = cyc[0]; h2_in = ~cyc[0]; hl_in = cyc[1];
    cyc++;
    @(posedge clk);
    if (hd_v || vd_v) begin
      started = 1'b1;
      k = 0;
      seq_l = sq;
      if (vd_v) line_no = 0;
      else      line_no = line_no + 1;
    end else if (k < 255) begin
      k++;
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic run_line(input logic use_hd, input logic use_vd, input logic sq, input int len);
    tick(use_hd, use_vd, sq);
    for (int c = 1; c < len; c++)
      tick(1'b0, 1'b0, (c >= 20) ? ~sq : sq);   // R9: mid-line select change
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; vd = 1'b0; hd = 1'b0; seq_sel = 1'b0;
    h1_in = 1'b0; h2_in = 1'b1; hl_in = 1'b0;
    // seq 0 even: six positions, two extra pulse groups (R3)
    tog_even[0] = {8'd27, 8'd25, 8'd20, 8'd18, 8'd12, 8'd5};
    // seq 0 odd: standard window, rest disabled (R4)
    tog_odd[0]  = {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'd30, 8'd3};
    // seq 1 even: duplicate pair cancels, last on final pixel clashes with hd (R2)
    tog_even[1] = {8'd39, 8'd35, 8'hFF, 8'd15, 8'd8, 8'd8};
    // seq 1 odd: early positions and one near saturation (R4)
    tog_odd[1]  = {8'd254, 8'd11, 8'd10, 8'd2, 8'd1, 8'd0};
    park_lo_h1 = 2'b01; park_lo_h2 = 2'b10; park_lo_hl = 2'b01;
    repeat (3) @(negedge clk);
    vectors++;
    if (hblk !== 1'b0) begin
      fails++;
      $display("FAIL R1 hblk in reset actual=%b expected=0", hblk);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b0, 1'b0);   // R1

    for (int ln = 0; ln < 16; ln++) begin
      logic sq;
      sq = ln[1];
      long_line = (ln == 14);
      if (ln == 0)      run_line(1'b0, 1'b1, sq, LINE_LEN);   // R5 frame start
      else if (ln == 9) run_line(1'b1, 1'b1, sq, LINE_LEN);   // R10 both strobes
      else              run_line(1'b1, 1'b0, sq, long_line ? 300 : LINE_LEN);
    end
    long_line = 1'b0;

    park_lo_h1 = 2'b10; park_lo_h2 = 2'b01; park_lo_hl = 2'b10;
    tick(1'b0, 1'b1, 1'b1);
    for (int c = 1; c < LINE_LEN; c++) tick(1'b0, 1'b0, 1'b1);
    for (int ln = 0; ln < 8; ln++)
      run_line(1'b1, 1'b0, ln[0], LINE_LEN);
    tick(1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule